// File: doc/BRIEF.md
# Two-Port Memory Collision Arbiter

This block is a small two-port word memory with collision logic built around it. Each port (left and right) has an enable, an address, a write strobe, write data and registered read data. Two ports collide when both are enabled on the same address in the same cycle. Whether either access reads or writes plays no part in this. On a collision one port wins and the other port sees a busy flag. A write from the losing port is dropped inside the block, so the memory holds only the winner's data.

A mode input chooses between arbitrating and following. In arbitrating mode the block makes the decision and drives its busy outputs. In following mode its own decision is not used: the busy outputs stay low and each port's busy input acts only as a write inhibit for that port. Several instances can be placed side by side to make a wider word. One instance arbitrates, and its busy outputs feed the busy inputs of the others, so every slice makes the same choice in the same cycle. The busy flags are combinational from the current inputs and the registered history, so they are settled before the clock edge that would commit the write.

Top module: `dpcoll_arbiter`

## Requirements
- R1: In arbitrating mode (`master`=1), when both ports are enabled with equal addresses, exactly one of `l_busy_out`/`r_busy_out` is high in that same cycle, whatever the write strobes are.
- R2: A busy output is never high unless the block is in arbitrating mode and both ports collide in that cycle.
- R3: When a collision starts and neither port held the address alone in the previous cycle, the left port wins (`r_busy_out`=1).
- R4: When the right port was enabled on the address in the previous cycle and the left port was not on that address, the right port wins the new collision (`l_busy_out`=1).
- R5: While a collision continues at the same address on consecutive cycles, the port that won in the previous cycle keeps winning.
- R6: An enabled write from a port whose busy flag is high leaves the memory unchanged. The winner's write is stored.
- R7: Every enabled access returns on its port's read data one cycle later the word stored before that edge (read-first), including accesses by a losing port. A disabled port holds its read data.
- R8: In following mode (`master`=0), both busy outputs are low, and a high busy input blocks every write from that port.
- R9: In following mode, a low busy input gives normal writes. If both ports write the same address in one cycle, the left port's data is stored.
- R10: In arbitrating mode, the busy inputs have no effect.
- R11: The asynchronous active-low reset clears the memory, both read data outputs and the collision history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master | input | 1 | 1 = arbitrating mode, 0 = following mode |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | AW | Left port word address |
| l_wdata | input | DW | Left port write data |
| l_rdata | output | DW | Left port read data, registered |
| l_busy_in | input | 1 | Left write inhibit in following mode |
| l_busy_out | output | 1 | Left port lost the collision |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | AW | Right port word address |
| r_wdata | input | DW | Right port write data |
| r_rdata | output | DW | Right port read data, registered |
| r_busy_in | input | 1 | Right write inhibit in following mode |
| r_busy_out | output | 1 | Right port lost the collision |

## Verification
The bench concentrates on the priority corners. It covers a fresh tie, a right port that already held the address before the left port arrived, and a collision held over several cycles. A design with a fixed priority would let the wrong write land in the second and third cases. It also covers both ports writing one address in both modes: if the inhibit were not gated, the memory would hold the loser's word. A design that only arbitrated writes would miss read-read collisions. A design that looked at the busy inputs in arbitrating mode, or drove busy outputs in following mode, would drop writes that should land.

// File: rtl/dpcoll_pkg.sv
package dpcoll_pkg;

  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } win_e;

  // Priority choice for a collision in the current cycle.
  // cont      : the previous cycle collided at this same address
  // prev_win  : winner of that previous collision
  // r_held    : right was on this address last cycle, left was not
  function automatic win_e pick_winner(input logic cont, input win_e prev_win,
                                       input logic r_held);
    if (cont) return prev_win;
    return r_held ? WIN_RIGHT : WIN_LEFT;
  endfunction

endpackage

// File: rtl/dpcoll_detect.sv
module dpcoll_detect #(
  parameter int AW = 6
) (
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic          hit
);
  always_comb hit = a_en && b_en && (a_addr == b_addr);
endmodule

// File: rtl/dpcoll_prio.sv
module dpcoll_prio
  import dpcoll_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  output win_e          win
);
  logic          h_hit;
  win_e          h_win;
  logic          h_l_en, h_r_en;
  logic [AW-1:0] h_l_addr, h_r_addr;
  logic          cont, r_held;

  always_comb begin
    cont   = h_hit && (h_l_addr == l_addr);
    r_held = h_r_en && (h_r_addr == r_addr) && !(h_l_en && (h_l_addr == l_addr));
    win    = pick_winner(cont, h_win, r_held);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_hit    <= 1'b0;
      h_win    <= WIN_LEFT;
      h_l_en   <= 1'b0;
      h_r_en   <= 1'b0;
      h_l_addr <= '0;
      h_r_addr <= '0;
    end else begin
      h_hit    <= hit;
      h_win    <= win;
      h_l_en   <= l_en;
      h_r_en   <= r_en;
      h_l_addr <= l_addr;
      h_r_addr <= r_addr;
    end
  end
endmodule

// File: rtl/dpcoll_mem.sv
module dpcoll_mem #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic          l_fire,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_en,
  input  logic          r_fire,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_en) l_rdata <= store[l_addr];
      if (r_en) r_rdata <= store[r_addr];
      // Right first, left last: left data lands when both hit one word.
      if (r_fire) store[r_addr] <= r_wdata;
      if (l_fire) store[l_addr] <= l_wdata;
    end
  end
endmodule

// File: rtl/dpcoll_arbiter.sv
module dpcoll_arbiter
  import dpcoll_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          l_busy_in,
  output logic          l_busy_out,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  input  logic          r_busy_in,
  output logic          r_busy_out
);
  logic hit;
  win_e win;
  logic l_inh, r_inh;
  logic l_wr_fire, r_wr_fire;

  dpcoll_detect #(.AW(AW)) u_det (
    .a_en(l_en), .a_addr(l_addr), .b_en(r_en), .b_addr(r_addr), .hit(hit)
  );

  dpcoll_prio #(.AW(AW)) u_prio (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr), .win(win)
  );

  always_comb begin
    l_busy_out = master && hit && (win == WIN_RIGHT);
    r_busy_out = master && hit && (win == WIN_LEFT);
    l_inh      = master ? l_busy_out : l_busy_in;
    r_inh      = master ? r_busy_out : r_busy_in;
    l_wr_fire  = l_en && l_we && !l_inh;
    r_wr_fire  = r_en && r_we && !r_inh;
  end

  dpcoll_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_fire(l_wr_fire), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_en(r_en), .r_fire(r_wr_fire), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );
endmodule

// File: rtl/dpcoll_checker.sv
module dpcoll_checker #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master,
  input logic          l_en,
  input logic [AW-1:0] l_addr,
  input logic          r_en,
  input logic [AW-1:0] r_addr,
  input logic          hit,
  input logic          l_busy_in,
  input logic          r_busy_in,
  input logic          l_busy_out,
  input logic          r_busy_out,
  input logic          l_wr_fire,
  input logic          r_wr_fire
);
  a_r1_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
    (master && l_en && r_en && l_addr == r_addr) |-> ($countones({l_busy_out, r_busy_out}) == 1));

  a_r2_busy_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_out || r_busy_out) |-> (master && hit));

  a_r5_keep_right: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $past(master) && hit && $past(hit) && l_addr == $past(l_addr) && $past(r_busy_out))
      |-> r_busy_out);

  a_r5_keep_left: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $past(master) && hit && $past(hit) && l_addr == $past(l_addr) && $past(l_busy_out))
      |-> l_busy_out);

  a_r6_loser_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_out |-> !l_wr_fire) and (r_busy_out |-> !r_wr_fire));

  a_r8_follow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (!l_busy_out && !r_busy_out));

  a_r8_follow_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && l_busy_in) |-> !l_wr_fire);

  a_r8_follow_inhibit_r: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && r_busy_in) |-> !r_wr_fire);
endmodule

bind dpcoll_arbiter dpcoll_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master(master),
  .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr),
  .hit(hit), .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
  .l_busy_out(l_busy_out), .r_busy_out(r_busy_out),
  .l_wr_fire(l_wr_fire), .r_wr_fire(r_wr_fire)
);

// File: tb/sim_dpcoll_arbiter.sv
module sim_dpcoll_arbiter;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam time PER = 10;

  logic clk = 0, rst_n = 0, master = 1;
  logic l_en = 0, l_we = 0, l_busy_in = 0, r_en = 0, r_we = 0, r_busy_in = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_out, r_busy_out;

  int total = 0, bad = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  dpcoll_arbiter #(.AW(AW), .DW(DW)) u0 (.*);

  // reference model
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_lrd, m_rrd;
  bit p_coll, p_winr, p_le, p_re;
  logic [AW-1:0] p_la, p_ra;

  function automatic bit f_coll(bit le, logic [AW-1:0] la, bit re, logic [AW-1:0] ra);
    return le && re && (la == ra);
  endfunction

  function automatic bit f_right_wins(bit cont, bit prev_r, bit held);
    if (cont) return prev_r;
    return held;
  endfunction

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(bit ms, bit le, bit lw, logic [AW-1:0] la, logic [DW-1:0] ld, bit lbi,
                      bit re, bit rw, logic [AW-1:0] ra, logic [DW-1:0] rd, bit rbi,
                      string rtag);
    bit c, cont, held, winr, ebl, ebr, linh, rinh;
    string btag;
    master = ms; l_en = le; l_we = lw; l_addr = la; l_wdata = ld; l_busy_in = lbi;
    r_en = re; r_we = rw; r_addr = ra; r_wdata = rd; r_busy_in = rbi;
    #1;
    c    = f_coll(le, la, re, ra);
    cont = p_coll && (p_la == la);
    held = p_re && (p_ra == ra) && !(p_le && (p_la == la));
    winr = f_right_wins(cont, p_winr, held);
    ebl  = ms && c && winr;
    ebr  = ms && c && !winr;
    if (!ms) btag = "R8";
    else if (!c) btag = "R2";
    else if (cont) btag = "R1 R5";
    else if (held) btag = "R1 R4";
    else btag = "R1 R3";
    check({btag, " l_busy"}, DW'(l_busy_out), DW'(ebl));
    check({btag, " r_busy"}, DW'(r_busy_out), DW'(ebr));
    linh = ms ? ebl : lbi;
    rinh = ms ? ebr : rbi;
    if (le) m_lrd = m_mem[la];
    if (re) m_rrd = m_mem[ra];
    @(posedge clk); #1;
    if (re && rw && !rinh) m_mem[ra] = rd;
    if (le && lw && !linh) m_mem[la] = ld;
    p_coll = c; p_winr = winr; p_le = le; p_re = re; p_la = la; p_ra = ra;
    check({rtag, " l_rdata"}, l_rdata, m_lrd);
    check({rtag, " r_rdata"}, r_rdata, m_rrd);
  endtask

  task automatic idle();
    step(1, 0, 0, '0, '0, 0, 0, 0, '0, '0, 0, "R7");
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_lrd = '0; m_rrd = '0;
    p_coll = 0; p_winr = 0; p_le = 0; p_re = 0; p_la = '0; p_ra = '0;
    void'($urandom(32'd20251));
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    check("R11 l_rdata", l_rdata, '0);
    check("R11 r_rdata", r_rdata, '0);
    check("R11 busy", DW'({l_busy_out, r_busy_out}), '0);
    rst_n = 1;
    @(posedge clk); #1;

    // R3 fresh tie, both write: left wins, right write dropped (R6)
    step(1, 1, 1, 6'd5, 16'hAAAA, 0, 1, 1, 6'd5, 16'h5555, 0, "R7");
    idle();
    step(1, 1, 0, 6'd5, '0, 0, 0, 0, '0, '0, 0, "R6");
    idle();
    // R4: right holds address, left joins with a write -> left blocked
    step(1, 0, 0, '0, '0, 0, 1, 0, 6'd9, '0, 0, "R7");
    step(1, 1, 1, 6'd9, 16'h1111, 0, 1, 0, 6'd9, '0, 0, "R7");
    // R5: collision persists, right keeps winning, right writes
    step(1, 1, 1, 6'd9, 16'h2222, 0, 1, 1, 6'd9, 16'h3333, 0, "R7");
    step(1, 1, 0, 6'd9, '0, 0, 1, 0, 6'd9, '0, 0, "R7");
    step(1, 1, 0, 6'd9, '0, 0, 0, 0, '0, '0, 0, "R6");
    // R1 read-read collision still raises busy; loser read returns data (R7)
    idle();
    step(1, 1, 0, 6'd9, '0, 0, 1, 0, 6'd9, '0, 0, "R7");
    idle();
    // R10: busy inputs ignored in arbitrating mode
    step(1, 1, 1, 6'd12, 16'hBEEF, 1, 1, 1, 6'd13, 16'hCAFE, 1, "R10");
    step(1, 1, 0, 6'd12, '0, 0, 1, 0, 6'd13, '0, 0, "R10");
    // R8 / R9 following mode
    step(0, 1, 1, 6'd20, 16'h0F0F, 1, 1, 1, 6'd21, 16'hF0F0, 0, "R8");
    step(0, 1, 0, 6'd20, '0, 0, 1, 0, 6'd21, '0, 0, "R8");
    step(0, 1, 1, 6'd22, 16'h1234, 0, 1, 1, 6'd22, 16'h4321, 0, "R9");
    step(0, 1, 0, 6'd22, '0, 0, 0, 0, '0, '0, 0, "R9");

    // constrained random, small address range to force collisions
    for (int n = 0; n < 3000; n++) begin
      bit ms;
      ms = ((n / 400) % 3) != 2;
      step(ms,
           ($urandom % 4) != 0, $urandom % 2, AW'($urandom % 4), DW'($urandom), $urandom % 2,
           ($urandom % 4) != 0, $urandom % 2, AW'($urandom % 4), DW'($urandom), $urandom % 2,
           "R7");
    end
    // final content scan through the left port
    for (int a = 0; a < DEPTH; a++)
      step(1, 1, 0, AW'(a), '0, 0, 0, 0, '0, '0, 0, "R6");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule